// File: doc/BRIEF.md
# Polyphase Interpolate-by-4 FIR Filter

This block raises the sample rate of a signed data stream by four. It implements a 16-tap low-pass prototype filter as four polyphase branches of four taps each. One four-lane multiply-add datapath is shared across the branches: on each fast-clock cycle it uses a different group of four coefficients, so every accepted input sample yields four filtered output samples.

The whole block runs on one fast clock. A two-bit phase counter picks the coefficient group. In the last phase the block raises a ready strobe, which asks the source for the next sample, and captures that sample as the counter wraps to phase 0. The four most recent samples sit in a short delay line that stays unchanged across the four phases. The coefficients are a parameter of the block, so they form a constant table held inside it. A clock-enable input freezes all state while it is low.

Top module: `poly4_interp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the phase to 0, clears the sample delay line to zero and drives `dout` to 0, with `ready` low.
- R2: The phase advances by one on each clock edge where `clk_en` is high, going 0,1,2,3,0. `ready` is high exactly while the phase is 3, so after reset it first rises after three enabled edges.
- R3: The value on `din` is taken into the delay line only at an edge where `ready` and `clk_en` are both high. At every other edge `din` is ignored and has no effect on any later `dout`.
- R4: At each enabled edge, `dout` is loaded with the filtered value of the phase p that was current before that edge: sum over i=0..3 of s(i)*h(p+4*i). Here s(0) is the newest stored sample and s(3) the oldest.
- R5: The coefficient groups are {h0,h4,h8,h12} in phase 0, {h1,h5,h9,h13} in phase 1, {h2,h6,h10,h14} in phase 2 and {h3,h7,h11,h15} in phase 3. h(k) sits at bits [18k+17:18k] of the coefficient parameter. After reset, feeding one sample of 4096 followed by zeros gives h0, h1, ..., h15 on consecutive enabled outputs.
- R6: The sum is formed at full 38-bit precision. `dout` is the sum shifted right arithmetically by 12 (rounding toward minus infinity), and it never wraps, even when every sample and every coefficient is -131072.
- R7: At an edge where `clk_en` is low, `dout`, `ready`, the phase and the delay line all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four ticks per input sample |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; all state holds while it is low |
| din | input | 18 | Signed input sample, captured when `ready` and `clk_en` are high |
| ready | output | 1 | High during phase 3; the source must present the next sample |
| dout | output | 26 | Signed filtered output, registered, one per enabled cycle |

## Verification
The checker evaluates some rules on every cycle. With the enable low, the output, the ready strobe and the delay line hold. Ready never stays high across an enabled edge. A capture puts exactly the presented sample into the newest tap. Reset forces a zero output with ready low. The numeric behaviour needs the bench's scenarios to show it: that each phase uses the right coefficient group and that the truncated sum is correct at full scale. The bench's reference model, its impulse run and its extreme-value run cover this. They also show that samples presented outside a capture cycle are dropped.

// File: rtl/poly4_pkg.sv
package poly4_pkg;

    // Default widths and geometry of the interpolator
    localparam int DEF_IN_W   = 18;
    localparam int DEF_COEF_W = 18;
    localparam int DEF_OUT_W  = 26;
    localparam int DEF_NTAPS  = 16;
    localparam int DEF_FACTOR = 4;

    // Default symmetric low-pass prototype, h(15) in the top slot down to h(0)
    localparam logic [DEF_NTAPS*DEF_COEF_W-1:0] DEF_COEFS = {
        -18'sd120,  -18'sd310,  18'sd0,     18'sd1450,
         18'sd4100,  18'sd8200, 18'sd12400, 18'sd15000,
         18'sd15000, 18'sd12400, 18'sd8200, 18'sd4100,
         18'sd1450,  18'sd0,    -18'sd310,  -18'sd120
    };

    // Width of a signed sum of n products of the given operand widths
    function automatic int sum_width(input int a_w, input int b_w, input int n);
        int g;
        g = 0;
        while ((1 << g) < n) g++;
        return a_w + b_w + g;
    endfunction

endpackage

// File: rtl/poly4_phase_seq.sv
module poly4_phase_seq #(
    parameter int FACTOR = 4,
    localparam int PH_W  = (FACTOR > 1) ? $clog2(FACTOR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en,
    output logic [PH_W-1:0] phase,
    output logic            last
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FACTOR - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (st_q.ph == LAST_PH) st_d.ph = '0;
            else                    st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign last  = (st_q.ph == LAST_PH);

endmodule

// File: rtl/poly4_delay_line.sv
module poly4_delay_line #(
    parameter int DEPTH = 4,
    parameter int W     = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift,
    input  logic [W-1:0]             din,
    output logic [DEPTH-1:0][W-1:0]  taps
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] s;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (shift) begin
            ln_d.s[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                ln_d.s[i] = ln_q.s[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '0;
        else     ln_q <= ln_d;
    end

    assign taps = ln_q.s;

endmodule

// File: rtl/poly4_coef_sel.sv
module poly4_coef_sel #(
    parameter int FACTOR = 4,
    parameter int BRANCH = 4,
    parameter int COEF_W = 18,
    parameter logic [FACTOR*BRANCH*COEF_W-1:0] COEFS = '0,
    localparam int PH_W  = (FACTOR > 1) ? $clog2(FACTOR) : 1
) (
    input  logic [PH_W-1:0]                 phase,
    output logic [BRANCH-1:0][COEF_W-1:0]   coefs
);

    // Lane i of phase p uses prototype tap p + FACTOR*i
    for (genvar i = 0; i < BRANCH; i++) begin : g_lane
        logic [FACTOR-1:0][COEF_W-1:0] lane_tab;
        for (genvar p = 0; p < FACTOR; p++) begin : g_ph
            assign lane_tab[p] = COEFS[(p + FACTOR*i)*COEF_W +: COEF_W];
        end
        assign coefs[i] = lane_tab[phase];
    end

endmodule

// File: rtl/poly4_mac.sv
module poly4_mac #(
    parameter int LANES  = 4,
    parameter int IN_W   = 18,
    parameter int COEF_W = 18,
    parameter int OUT_W  = 26,
    localparam int PROD_W = IN_W + COEF_W,
    localparam int ACC_W  = poly4_pkg::sum_width(IN_W, COEF_W, LANES),
    localparam int SHIFT  = ACC_W - OUT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clk_en,
    input  logic [LANES-1:0][IN_W-1:0]    samples,
    input  logic [LANES-1:0][COEF_W-1:0]  coefs,
    output logic [OUT_W-1:0]              result
);

    typedef struct packed {
        logic [OUT_W-1:0] res;
    } mac_t;

    mac_t mc_d, mc_q;

    logic signed [LANES-1:0][PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]             acc;

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        assign prod[i] = $signed(samples[i]) * $signed(coefs[i]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            acc = acc + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    always_comb begin
        mc_d = mc_q;
        if (clk_en) mc_d.res = acc[SHIFT +: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) mc_q <= '0;
        else     mc_q <= mc_d;
    end

    assign result = mc_q.res;

endmodule

// File: rtl/poly4_interp.sv
module poly4_interp #(
    parameter int IN_W   = poly4_pkg::DEF_IN_W,
    parameter int COEF_W = poly4_pkg::DEF_COEF_W,
    parameter int OUT_W  = poly4_pkg::DEF_OUT_W,
    parameter int NTAPS  = poly4_pkg::DEF_NTAPS,
    parameter int FACTOR = poly4_pkg::DEF_FACTOR,
    parameter logic [NTAPS*COEF_W-1:0] COEFS = poly4_pkg::DEF_COEFS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [IN_W-1:0]  din,
    output logic             ready,
    output logic [OUT_W-1:0] dout
);

    localparam int BRANCH = NTAPS / FACTOR;
    localparam int PH_W   = (FACTOR > 1) ? $clog2(FACTOR) : 1;

    logic [PH_W-1:0]                phase_w;
    logic                           last_w;
    logic                           capture_w;
    logic [BRANCH-1:0][IN_W-1:0]    taps_w;
    logic [BRANCH-1:0][COEF_W-1:0]  coefs_w;

    poly4_phase_seq #(.FACTOR(FACTOR)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .phase  (phase_w),
        .last   (last_w)
    );

    assign capture_w = last_w & clk_en;

    poly4_delay_line #(.DEPTH(BRANCH), .W(IN_W)) line_i (
        .clk   (clk),
        .rst   (rst),
        .shift (capture_w),
        .din   (din),
        .taps  (taps_w)
    );

    poly4_coef_sel #(
        .FACTOR (FACTOR),
        .BRANCH (BRANCH),
        .COEF_W (COEF_W),
        .COEFS  (COEFS)
    ) csel_i (
        .phase (phase_w),
        .coefs (coefs_w)
    );

    poly4_mac #(
        .LANES  (BRANCH),
        .IN_W   (IN_W),
        .COEF_W (COEF_W),
        .OUT_W  (OUT_W)
    ) mac_i (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .samples (taps_w),
        .coefs   (coefs_w),
        .result  (dout)
    );

    assign ready = last_w;

endmodule

// File: rtl/poly4_interp_chk.sv
module poly4_interp_chk #(
    parameter int IN_W   = 18,
    parameter int OUT_W  = 26,
    parameter int BRANCH = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clk_en,
    input logic [IN_W-1:0]         din,
    input logic                    ready,
    input logic [OUT_W-1:0]        dout,
    input logic [BRANCH*IN_W-1:0]  taps
);

    // R1: reset leaves a zero output and ready low
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dout == '0 && !ready));

    // R2: ready lasts one enabled cycle, phase 3 is followed by phase 0
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && clk_en) |=> !ready);

    // R3: a capture places the presented sample in the newest tap
    assert_capture_sample_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && clk_en) |=> (taps[IN_W-1:0] == $past(din)));

    // R3: outside a capture the delay line does not move
    assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(ready && clk_en) |=> $stable(taps));

    // R7: enable low freezes output and ready
    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(dout) && $stable(ready)));

endmodule

bind poly4_interp poly4_interp_chk #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .BRANCH (BRANCH)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .din    (din),
    .ready  (ready),
    .dout   (dout),
    .taps   (taps_w)
);

// File: tb/poly4_interp_tb_top.sv
module poly4_interp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W   = 18;
    localparam int COEF_W = 18;
    localparam int OUT_W  = 26;

    // Distinct, asymmetric coefficients so phase ordering errors show; h(15) first
    localparam logic [16*COEF_W-1:0] TB_COEFS = {
        18'sd907,  -18'sd2210, 18'sd3333, 18'sd44,
        -18'sd777, 18'sd131071, 18'sd6000, -18'sd15,
        18'sd12345, -18'sd4096, -18'sd131072, 18'sd2500,
        18'sd81,   -18'sd1999, 18'sd5150, 18'sd23
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clk_en = 1'b0;
    logic [IN_W-1:0]  din = '0;
    logic             ready;
    logic [OUT_W-1:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint m_dl[4];
    int     m_ph;
    longint m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly4_interp #(.COEFS(TB_COEFS)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .din    (din),
        .ready  (ready),
        .dout   (dout)
    );

    function automatic longint coef(input int k);
        return longint'($signed(TB_COEFS[k*COEF_W +: COEF_W]));
    endfunction

    function automatic longint phase_sum(input int ph);
        longint acc = 0;
        for (int i = 0; i < 4; i++) acc += m_dl[i] * coef(ph + 4*i);
        return acc;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs for one edge, advance the model, then compare at the next negedge
    task automatic step(input bit r, input bit en, input longint x, input string req);
        rst    = r;
        clk_en = en;
        din    = IN_W'(x);
        if (r) begin
            for (int i = 0; i < 4; i++) m_dl[i] = 0;
            m_ph = 0; m_out = 0;
        end else if (en) begin
            m_out = phase_sum(m_ph) >>> 12;
            if (m_ph == 3) begin
                for (int i = 3; i > 0; i--) m_dl[i] = m_dl[i-1];
                m_dl[0] = x;
            end
            m_ph = (m_ph + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " dout"}, longint'($signed(dout)), m_out);
        check({req, " ready (R2)"}, longint'(ready), longint'(m_ph == 3));
    endtask

    function automatic longint rnd_sample();
        return longint'($signed(IN_W'($urandom)));
    endfunction

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 4; i++) m_dl[i] = 0;
        m_ph = 0; m_out = 0;
        @(negedge clk);

        // R1: reset state
        step(1'b1, 1'b1, 77, "R1");
        step(1'b1, 1'b0, 5, "R1");

        // R5: impulse of 4096 walks out h0..h15 in order
        for (int c = 0; c < 24; c++) begin
            step(1'b0, 1'b1, (c == 3) ? 4096 : ((m_ph == 3) ? 0 : rnd_sample()), "R5");
        end

        // R3/R4/R7: random samples, random enable, junk on din outside capture
        for (int c = 0; c < 3000; c++) begin
            bit en = ($urandom_range(0, 3) != 0);
            step(1'b0, en, rnd_sample(), "R3/R4/R7");
        end

        // R7: long stretch with enable low
        for (int c = 0; c < 20; c++) step(1'b0, 1'b0, rnd_sample(), "R7");

        // R6: full-scale negative samples against extreme coefficients
        for (int c = 0; c < 40; c++) step(1'b0, 1'b1, -131072, "R6");
        for (int c = 0; c < 40; c++) step(1'b0, 1'b1, 131071, "R6");
        for (int c = 0; c < 40; c++) step(1'b0, 1'b1, (c % 8 < 4) ? -131072 : 131071, "R6");

        // R1: reset in the middle of a run, then R2 phase restart
        step(1'b1, 1'b1, 0, "R1");
        for (int c = 0; c < 12; c++) step(1'b0, 1'b1, rnd_sample(), "R2/R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule